// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block is the transmit half of a descriptor-driven Ethernet DMA. Software prepares a ring of descriptors in shared memory. Each descriptor is 8 bytes: a status word at offset 0 and a buffer address word at offset 4. To hand a descriptor to the engine, software writes the buffer address, then writes the status word with the ownership bit set, the first/last buffer flags and the byte length.

While enabled, the engine keeps re-reading the status word of its current ring slot. When it finds a descriptor it owns, it reads the buffer as 32-bit words and sends the bytes, one at a time, to a MAC-side byte sink. It pads short frames with zeros up to the minimum frame length. It then writes the status word back with ownership cleared and a success flag. After that it moves to the next slot and wraps at the end of the ring.

Memory traffic uses a single request channel with valid/ready and one read outstanding. Read data comes back on a response strobe that the engine always accepts. On the byte stream, a byte moves only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the engine holds `tx_data` and `tx_last`. Likewise, a memory request holds its address, write flag and write data until `mem_req_ready` is sampled high.

Top module: `txdesc_fetch_engine`

## Requirements
- R1: When enabled and idle, the engine reads the status word of the current slot. If bit 31 (ownership) reads 0, it sends nothing, writes nothing back, and reads the slot again later.
- R2: For an owned descriptor with bit 26 (first) or bit 25 (last) set, the engine sends exactly the number of bytes in the low 16 bits of the status word. Bytes come in ascending address order, little-endian within each 32-bit word. The two low bits of the buffer address are ignored.
- R3: Each descriptor with the last flag closes a frame, and each descriptor with the first flag restarts the frame byte count. If a closed frame has fewer than 60 bytes, zero bytes follow until the frame reaches 60. A frame of 60 bytes or more gets no padding.
- R4: `tx_last` is high only with the final byte sent for a descriptor that carries the last flag. After that byte is accepted, `tx_valid` is low in the next cycle.
- R5: After the final byte of a good descriptor, the engine writes the status word back to offset 0. Bit 31 is cleared, bit 27 (success) is set, and all other bits keep the values software wrote.
- R6: A descriptor with ownership set but neither first nor last flagged causes no byte transfer. It is written back with bit 31 and bit 27 both cleared and all other bits unchanged, and it does not disturb the byte count of an open frame.
- R7: While `tx_en` is low, no new descriptor poll starts, and a descriptor already started runs to its write-back. Whenever the engine is disabled and idle, its slot index returns to 0. `busy` is low exactly when the engine is idle.
- R8: Slot i lies at `desc_base + 8*i`. The ring holds `ring_bytes/8` slots (rounded down, with at least one slot). The index wraps to 0 after the last slot.
- R9: Under back-pressure, `tx_data`/`tx_last` stay stable while `tx_valid` is high and `tx_ready` is low. A memory request keeps its address, write flag and data while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Enables descriptor processing |
| ring_bytes | input | 16 | Ring size in bytes (8 per slot) |
| desc_base | input | 32 | Byte address of slot 0 |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data (status write-back) |
| mem_rsp_valid | input | 1 | Read data strobe, one per accepted read |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of a frame |
| busy | output | 1 | Engine not idle |

## Verification
Some properties are checked on every cycle:
- Both channels stay stable under stall.
- Every status write-back has ownership cleared.
- The engine stays silent while it is disabled and idle.
- A frame end is always followed by a gap on the stream.

Other behaviours can only be shown by the bench's scenarios:
- Byte order, the padded counts at 59/60/61-byte boundaries and across two-buffer frames.
- The success or failure flag and the preserved bits in the written-back status.
- Ring wrap with a one-slot ring and an undersized ring size.
- The index reset after disabling.

// File: rtl/txdf_pkg.sv
package txdf_pkg;
  localparam int OWN_B      = 31;
  localparam int OK_B       = 27;
  localparam int FIRST_B    = 26;
  localparam int LAST_B     = 25;
  localparam int MIN_FRAME  = 60;
  localparam int DESC_BYTES = 8;
  localparam int ADDR_OFS   = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_POLL,
    ST_POLL_WAIT,
    ST_ADDR,
    ST_ADDR_WAIT,
    ST_STREAM,
    ST_FETCH,
    ST_FILL,
    ST_WBACK
  } fsm_t;
endpackage

// File: rtl/txdf_ring_index.sv
module txdf_ring_index
  import txdf_pkg::*;
#(
  parameter int RING_W = 16,
  parameter int IDX_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RING_W-1:0] ring_bytes,
  input  logic              clr,
  input  logic              adv,
  output logic [IDX_W-1:0]  idx
);
  localparam int SHIFT = $clog2(DESC_BYTES);

  logic [RING_W-1:0] entries;
  logic [IDX_W-1:0]  top_idx;

  always_comb begin
    entries = ring_bytes >> SHIFT;
    top_idx = (entries == '0) ? '0 : IDX_W'(entries - RING_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (clr)    idx <= '0;
    else if (adv)    idx <= (idx >= top_idx) ? '0 : idx + IDX_W'(1);
  end
endmodule

// File: rtl/txdf_frame_len.sv
module txdf_frame_len
  import txdf_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 6
) (
  input  logic [LEN_W-1:0] len,
  input  logic             first,
  input  logic             last,
  input  logic [CNT_W-1:0] acc,
  output logic [LEN_W-1:0] emit,
  output logic [CNT_W-1:0] acc_next
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] base, sum, minf;
  logic             short_frame;

  always_comb begin
    minf        = SUM_W'(MIN_FRAME);
    base        = first ? '0 : SUM_W'(acc);
    sum         = base + SUM_W'(len);
    short_frame = last && (sum < minf);
    emit        = short_frame ? LEN_W'(minf - base) : len;
    acc_next    = (sum >= minf) ? CNT_W'(MIN_FRAME) : CNT_W'(sum);
  end
endmodule

// File: rtl/txdf_byte_lane.sv
module txdf_byte_lane #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] word_in,
  input  logic [LANE_W-1:0] lane,
  input  logic              pad,
  output logic [7:0]        byte_out
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  always_comb byte_out = pad ? 8'h00 : word_q[{lane, 3'b000} +: 8];
endmodule

// File: rtl/txdesc_fetch_engine.sv
module txdesc_fetch_engine
  import txdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [RING_W-1:0] ring_bytes,
  input  logic [ADDR_W-1:0] desc_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              busy
);
  localparam int IDX_W  = RING_W - $clog2(DESC_BYTES);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = $clog2(MIN_FRAME + 1);
  localparam int BUF_W  = ADDR_W - LANE_W;

  fsm_t st_q, st_d;

  logic [IDX_W-1:0]  idx;
  logic              idx_clr, idx_adv;
  logic [DATA_W-1:0] sts_q, wb_word;
  logic [BUF_W-1:0]  buf_q;
  logic [LEN_W-1:0]  emit_q, pos_q, emit_d, len_w;
  logic [CNT_W-1:0]  acc_q, acc_d;
  logic              word_ok_q, good_q;
  logic              in_payload, at_end, lane_load;
  logic [ADDR_W-1:0] desc_addr, fetch_addr;

  assign len_w      = sts_q[LEN_W-1:0];
  assign in_payload = pos_q < len_w;
  assign at_end     = pos_q == emit_q;
  assign desc_addr  = desc_base + ADDR_W'({idx, 3'b000});
  assign fetch_addr = {buf_q, {LANE_W{1'b0}}}
                    + ADDR_W'({pos_q[LEN_W-1:LANE_W], {LANE_W{1'b0}}});
  assign lane_load  = (st_q == ST_FILL) && mem_rsp_valid;
  assign idx_clr    = (st_q == ST_IDLE) && !tx_en;
  assign busy       = st_q != ST_IDLE;

  txdf_ring_index #(.RING_W(RING_W), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .ring_bytes(ring_bytes),
    .clr(idx_clr), .adv(idx_adv), .idx(idx)
  );

  txdf_frame_len #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_len (
    .len(len_w), .first(sts_q[FIRST_B]), .last(sts_q[LAST_B]),
    .acc(acc_q), .emit(emit_d), .acc_next(acc_d)
  );

  txdf_byte_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .load(lane_load), .word_in(mem_rsp_data),
    .lane(pos_q[LANE_W-1:0]), .pad(!in_payload), .byte_out(tx_data)
  );

  always_comb begin
    wb_word        = sts_q;
    wb_word[OWN_B] = 1'b0;
    wb_word[OK_B]  = good_q;
  end

  always_comb begin
    st_d          = st_q;
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = desc_addr;
    mem_req_wdata = wb_word;
    tx_valid      = 1'b0;
    idx_adv       = 1'b0;
    case (st_q)
      ST_IDLE: if (tx_en) st_d = ST_POLL;
      ST_POLL: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = ST_POLL_WAIT;
      end
      ST_POLL_WAIT: if (mem_rsp_valid) begin
        if (!mem_rsp_data[OWN_B])                             st_d = ST_IDLE;
        else if (mem_rsp_data[FIRST_B] || mem_rsp_data[LAST_B]) st_d = ST_ADDR;
        else                                                   st_d = ST_WBACK;
      end
      ST_ADDR: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = desc_addr + ADDR_W'(ADDR_OFS);
        if (mem_req_ready) st_d = ST_ADDR_WAIT;
      end
      ST_ADDR_WAIT: if (mem_rsp_valid) st_d = ST_STREAM;
      ST_STREAM: begin
        if (at_end)                        st_d = ST_WBACK;
        else if (in_payload && !word_ok_q) st_d = ST_FETCH;
        else                               tx_valid = 1'b1;
      end
      ST_FETCH: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = fetch_addr;
        if (mem_req_ready) st_d = ST_FILL;
      end
      ST_FILL: if (mem_rsp_valid) st_d = ST_STREAM;
      ST_WBACK: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        if (mem_req_ready) begin
          idx_adv = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign tx_last = tx_valid && sts_q[LAST_B] && (pos_q == emit_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sts_q     <= '0;
      buf_q     <= '0;
      emit_q    <= '0;
      pos_q     <= '0;
      acc_q     <= '0;
      word_ok_q <= 1'b0;
      good_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      case (st_q)
        ST_POLL_WAIT: if (mem_rsp_valid) begin
          sts_q  <= mem_rsp_data;
          good_q <= mem_rsp_data[FIRST_B] | mem_rsp_data[LAST_B];
        end
        ST_ADDR_WAIT: if (mem_rsp_valid) begin
          buf_q     <= mem_rsp_data[ADDR_W-1:LANE_W];
          pos_q     <= '0;
          emit_q    <= emit_d;
          acc_q     <= acc_d;
          word_ok_q <= 1'b0;
        end
        ST_FILL: if (mem_rsp_valid) word_ok_q <= 1'b1;
        ST_STREAM: if (tx_valid && tx_ready) begin
          pos_q <= pos_q + LEN_W'(1);
          if (&pos_q[LANE_W-1:0]) word_ok_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txdf_checker.sv
module txdf_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last
);
  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R5
  wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> !mem_req_wdata[31]);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && !busy |=> !mem_req_valid && !tx_valid);

  // R4
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);
endmodule

bind txdesc_fetch_engine txdf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last)
);

// File: tb/sim_txdesc_fetch_engine.sv
`timescale 1ns/1ps
module sim_txdesc_fetch_engine;
  localparam logic [31:0] DB = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        tx_en = 1'b0;
  logic [15:0] ring_bytes = 16'd64;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        tx_valid, tx_last, busy;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;

  txdesc_fetch_engine u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ring_bytes(ring_bytes),
    .desc_base(DB), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .busy(busy)
  );

  logic [31:0] mem [0:4095];
  logic        hw_we = 1'b0;
  logic [31:0] hw_addr = '0, hw_data = '0;
  logic        cap_clr = 1'b0;
  bit          stall_on = 1'b0;
  logic [7:0]  cap   [0:4095];
  logic        cap_l [0:4095];
  int          cap_n = 0;

  always @(posedge clk) begin
    if (hw_we) mem[hw_addr[13:2]] <= hw_data;
    if (!rst_n) mem_rsp_valid <= 1'b0;
    else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) mem[mem_req_addr[13:2]] <= mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[mem_req_addr[13:2]];
        end
      end
    end
    mem_req_ready <= stall_on ? ($urandom % 4 != 0) : 1'b1;
    tx_ready      <= stall_on ? ($urandom % 3 != 0) : 1'b1;
    if (cap_clr) cap_n <= 0;
    else if (tx_valid && tx_ready && cap_n < 4096) begin
      cap[cap_n]   <= tx_data;
      cap_l[cap_n] <= tx_last;
      cap_n        <= cap_n + 1;
    end
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
    end
  endtask

  task automatic hw_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hw_we = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk);
    hw_we = 1'b0;
  endtask

  function automatic logic [7:0] bbyte(input int a);
    return mem[a >> 2][8 * (a % 4) +: 8];
  endfunction

  int         d_len   [0:7];
  bit         d_first [0:7];
  bit         d_last  [0:7];
  logic [31:0] d_sts  [0:7];
  logic [7:0] expb [0:4095];
  bit         expl [0:4095];

  task automatic setd(input int i, input int len, input bit f, input bit l);
    d_len[i] = len; d_first[i] = f; d_last[i] = l;
  endtask

  task automatic go_idle();
    int t;
    @(negedge clk);
    tx_en = 1'b0;
    t = 0;
    while (busy && t < 10000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_ring(input int n, input int entries, input int rb, input string tag);
    int t, slot, base, pos, facc, start, mism, lmis;
    logic [31:0] s, e;
    bit bad;
    go_idle();
    ring_bytes = rb[15:0];
    for (int k = 0; k < 8; k++) hw_write(DB + 32'(8 * k), 32'h0);
    @(negedge clk); cap_clr = 1'b1;
    @(negedge clk); cap_clr = 1'b0;
    tx_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      slot = i % entries;
      t = 0;
      while (mem[(DB + 8 * slot) >> 2][31] !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
      if (t >= 20000) chk(0, $sformatf("R8 %s slot %0d never released", tag, slot), t, 0);
      base = 32'h1000 + i * 32'h200;
      for (int w = 0; w < (d_len[i] + 3) / 4; w++) hw_write(32'(base + 4 * w), $urandom);
      hw_write(DB + 32'(8 * slot + 4), 32'(base));
      s = {1'b1, 3'($urandom), 1'($urandom), d_first[i], d_last[i], 9'($urandom), 16'(d_len[i])};
      d_sts[i] = s;
      hw_write(DB + 32'(8 * slot), s);
    end
    slot = (n - 1) % entries;
    t = 0;
    while (mem[(DB + 8 * slot) >> 2][31] !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, $sformatf("R5 %s completion seen", tag), t, 0);
    repeat (20) @(negedge clk);
    for (int k = 0; k < 4096; k++) expl[k] = 1'b0;
    pos = 0; facc = 0;
    for (int i = 0; i < n; i++) begin
      if (!d_first[i] && !d_last[i]) continue;
      if (d_first[i]) facc = 0;
      start = pos;
      base  = 32'h1000 + i * 32'h200;
      for (int b = 0; b < d_len[i]; b++) begin expb[pos] = bbyte(base + b); pos++; end
      facc += d_len[i];
      if (d_last[i]) begin
        while (facc < 60) begin expb[pos] = 8'h00; pos++; facc++; end
        if (pos > start) expl[pos - 1] = 1'b1;
      end
    end
    chk(cap_n == pos, $sformatf("R3 %s byte count", tag), cap_n, pos);
    mism = 0; lmis = 0;
    for (int k = 0; k < pos && k < cap_n; k++) begin
      if (cap[k] !== expb[k]) mism++;
      if (cap_l[k] !== expl[k]) lmis++;
    end
    chk(mism == 0, $sformatf("R2 %s byte values mismatched", tag), mism, 0);
    chk(lmis == 0, $sformatf("R4 %s last-flag positions mismatched", tag), lmis, 0);
    for (int i = (n > entries ? n - entries : 0); i < n; i++) begin
      slot = i % entries;
      bad  = !d_first[i] && !d_last[i];
      e    = d_sts[i] & ~32'h8000_0000;
      e    = bad ? (e & ~32'h0800_0000) : (e | 32'h0800_0000);
      chk(mem[(DB + 8 * slot) >> 2] === e,
          $sformatf("%s %s status desc %0d", bad ? "R6" : "R5", tag, i),
          mem[(DB + 8 * slot) >> 2], e);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 180000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R7: reset state
    chk(busy == 1'b0, "R7 busy at reset", busy, 0);
    chk(tx_valid == 1'b0, "R7 tx_valid at reset", tx_valid, 0);
    chk(mem_req_valid == 1'b0, "R7 request at reset", mem_req_valid, 0);
    rst_n = 1'b1;

    // R1: enabled, nothing owned
    ring_bytes = 16'd64;
    for (int k = 0; k < 8; k++) hw_write(DB + 32'(8 * k), 32'h0);
    @(negedge clk); cap_clr = 1'b1; @(negedge clk); cap_clr = 1'b0;
    tx_en = 1'b1;
    repeat (150) @(negedge clk);
    chk(cap_n == 0, "R1 bytes sent with no owned slot", cap_n, 0);
    chk(mem[DB >> 2] === 32'h0, "R1 status untouched", mem[DB >> 2], 0);

    // R7: disabled, owned descriptor waits
    go_idle();
    hw_write(DB + 4, 32'h1000);
    hw_write(DB, 32'h8600_0046);
    repeat (150) @(negedge clk);
    chk(cap_n == 0, "R7 bytes sent while disabled", cap_n, 0);
    chk(mem[DB >> 2][31] === 1'b1, "R7 ownership kept while disabled", mem[DB >> 2][31], 1);
    chk(busy == 1'b0, "R7 busy while disabled", busy, 0);

    setd(0, 100, 1, 1);                      run_ring(1, 8, 64, "single100");
    setd(0, 10, 1, 1);                       run_ring(1, 8, 64, "short10");
    setd(0, 0, 1, 1);                        run_ring(1, 8, 64, "empty");
    setd(0, 59, 1, 1); setd(1, 60, 1, 1); setd(2, 61, 1, 1);
    run_ring(3, 8, 64, "edge59-61");
    setd(0, 20, 1, 0); setd(1, 15, 0, 1); setd(2, 40, 1, 0); setd(3, 41, 0, 1);
    run_ring(4, 8, 64, "chain");
    setd(0, 30, 1, 1); setd(1, 50, 0, 0); setd(2, 70, 1, 1);
    run_ring(3, 8, 64, "malformed");
    setd(0, 12, 1, 1); setd(1, 80, 1, 1); setd(2, 33, 1, 1); setd(3, 64, 1, 1);
    run_ring(4, 3, 24, "wrap3");
    setd(0, 45, 1, 1); setd(1, 90, 1, 1);
    run_ring(2, 8, 64, "index-restart");
    setd(0, 7, 1, 1); setd(1, 66, 1, 1);
    run_ring(2, 1, 4, "tiny-ring");

    stall_on = 1'b1;
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 6; i++) begin
        int kind;
        kind = $urandom % 4;
        if (i == 0) setd(i, 1 + $urandom % 300, 1, 1'($urandom));
        else        setd(i, 1 + $urandom % 300, kind[0], kind[1]);
      end
      run_ring(6, 4, 32, $sformatf("random%0d", r));
    end
    setd(0, 3, 1, 1); setd(1, 200, 1, 1);
    run_ring(2, 8, 64, "stalled-directed");

    go_idle();
    summary();
    $finish;
  end
endmodule